// File: doc/BRIEF.md
# Multi-Channel Byte-Copy DMA Engine

This block moves bytes for several independent channels over one shared single-beat memory master. Software programs each channel through a 32-bit register bus with a source address, a destination address, an address stepping mode for each side and a byte count. A shared command word then starts or aborts any set of channels at once. Because each side can step up, step down or stay put, one engine serves memory-to-memory, memory-to-peripheral and peripheral-to-memory copies.

The engine serves busy channels in rotation. Each turn is one beat: a read at the channel's source followed by a write of that word to its destination. The channel's byte counter then drops by the size of the beat and both addresses step. Software can read the counter and the addresses at any time to see how far a copy has got. Completion and abort are latched as interrupt requests. Each request can be masked, and each channel drives its own interrupt pin, which stays low unless an enabled request is pending, so several channels may share one line.

Top module: `dma_multichan`

## Requirements
- R1: After reset no channel is busy, every interrupt output is low, the memory port is idle, and the channel registers read zero.
- R2: A register write to offset 0x000 with bit 31 clear starts every channel N whose bit N is set. Several channels can start in one write.
- R3: A start sent to a busy channel is ignored, so that channel moves the same bytes as with a single start. A start on an idle channel whose count is zero moves nothing and sets its DONE request (bit 1) at once.
- R4: In a channel window (base 0x100 + 0x40 * N), bits [5:4] of the source mode (0x20) and destination mode (0x24) registers select how that side's address moves after each beat: 0 adds 4, 1 subtracts 4, 2 leaves it fixed.
- R5: A beat reads the channel's current source address and then writes that word to its current destination address. The byte-size output is 4 on every beat except the last, which carries the 1 to 3 bytes left over.
- R6: The count register (0x28 source, 0x2C destination, 0x30 count) reads the bytes still to be moved while the channel runs. The channel goes idle when the count reaches zero, and the address registers then hold their stepped final values.
- R7: A write to 0x000 with bit 31 set aborts every channel whose bit is set. By the next cycle the channel is idle and both its ABORT request (bit 13) and its DONE request (bit 1) are set. A beat already on the bus completes but changes no channel register.
- R8: Offset 0x14 holds the latched requests and is write-1-to-clear. Offset 0x18 is the enable mask. Offset 0x1C reads requests AND enables. Bit 0 of the live status at 0x10 reads 1 while the channel is busy.
- R9: A channel's interrupt output is high exactly when it has an enabled pending request. A channel with nothing detected keeps its output low.
- R10: Busy channels get beats in round-robin order. Right after reset channel 0 goes first.
- R11: Once the engine raises memValid, it holds memValid, memWrite and memAddr steady until memReady accepts the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 for write, 0 for read |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Write data |
| memBytes | output | 3 | Valid bytes in the beat (1 to 4) |
| memReady | input | 1 | Memory accepts the request; read data valid |
| memRdata | input | 32 | Read data, sampled with memReady |
| irq | output | NUM_CH | Interrupt output for each channel |

## Verification
The assertions check on every cycle that a request waiting on memReady holds steady, that every write beat carries a non-zero byte size, that an abort leaves its channel idle with both requests latched one cycle later, and that a zero-byte start completes at once. Only the bench scenarios can show that the address sequence matches the stepping modes, that the data lands at the right places, that the final beat is the short one, and that two channels really alternate. The same goes for the live count seen mid-transfer, for a repeated start leaving a copy unchanged, and for interrupt lines on different channels staying separate.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int IRQ_DONE_BIT  = 1;
  localparam int IRQ_ABORT_BIT = 13;
  localparam int CMD_ABORT_BIT = 31;

  localparam logic [5:0] OFF_STAT  = 6'h10;
  localparam logic [5:0] OFF_REQ   = 6'h14;
  localparam logic [5:0] OFF_EN    = 6'h18;
  localparam logic [5:0] OFF_DET   = 6'h1C;
  localparam logic [5:0] OFF_SMODE = 6'h20;
  localparam logic [5:0] OFF_DMODE = 6'h24;
  localparam logic [5:0] OFF_SADDR = 6'h28;
  localparam logic [5:0] OFF_DADDR = 6'h2C;
  localparam logic [5:0] OFF_COUNT = 6'h30;

  typedef enum logic [1:0] {
    STEP_UP   = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_HOLD = 2'd2
  } stepMode_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_READ,
    ENG_WRITE
  } engState_e;

  typedef struct packed {
    logic captureData;
    logic writePhase;
  } dpStrobe_t;
endpackage

// File: rtl/dmac_dpath.sv
module dmac_dpath
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] curSrc,
  input  logic [ADDR_W-1:0] curDst,
  input  logic [1:0]        curSrcMode,
  input  logic [1:0]        curDstMode,
  input  logic [ADDR_W-1:0] curCount,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [2:0]        memBytes,
  output logic [ADDR_W-1:0] nextSrc,
  output logic [ADDR_W-1:0] nextDst,
  output logic [ADDR_W-1:0] nextCount
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [DATA_W-1:0] dataReg;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] m);
    case (m)
      STEP_UP:   return a + STEP;
      STEP_DOWN: return a - STEP;
      default:   return a;
    endcase
  endfunction

  always_comb begin
    if (curCount >= STEP) memBytes = 3'(WORD_BYTES);
    else                  memBytes = curCount[2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   dataReg <= '0;
    else if (strobe.captureData) dataReg <= memRdata;
  end

  assign memWdata  = dataReg;
  assign memAddr   = strobe.writePhase ? curDst : curSrc;
  assign nextSrc   = stepAddr(curSrc, curSrcMode);
  assign nextDst   = stepAddr(curDst, curDstMode);
  assign nextCount = curCount - {{(ADDR_W-3){1'b0}}, memBytes};

  AST_BEAT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writePhase |-> (memBytes != 3'd0 && memBytes <= 3'(WORD_BYTES))); // R5
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memValid,
  output logic              memWrite,
  input  logic              memReady,
  output logic [NUM_CH-1:0] irq,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] curSrc,
  output logic [ADDR_W-1:0] curDst,
  output logic [1:0]        curSrcMode,
  output logic [1:0]        curDstMode,
  output logic [ADDR_W-1:0] curCount,
  input  logic [ADDR_W-1:0] nextSrc,
  input  logic [ADDR_W-1:0] nextDst,
  input  logic [ADDR_W-1:0] nextCount
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [REG_AW-1:0] CH_BASE  = REG_AW'(12'h100);
  localparam logic [REG_AW-1:0] NUM_CH_R = REG_AW'(NUM_CH);

  logic [ADDR_W-1:0] srcAddr [NUM_CH];
  logic [ADDR_W-1:0] dstAddr [NUM_CH];
  logic [ADDR_W-1:0] count   [NUM_CH];
  logic [1:0]        srcMode [NUM_CH];
  logic [1:0]        dstMode [NUM_CH];
  logic [NUM_CH-1:0] busy, reqDone, reqAbort, enDone, enAbort;
  logic [NUM_CH-1:0] startHit, abortHit, beatDone, doneEvt;

  engState_e engState;
  logic [CH_W-1:0] curCh, lastCh, pickCh, selCh;
  logic pickValid, cmdWr, chValid;
  logic [REG_AW-1:0] chOff;
  logic [5:0] winReg;

  // address decode
  assign cmdWr   = regWrEn && (regAddr == '0);
  assign chOff   = regAddr - CH_BASE;
  assign chValid = (regAddr >= CH_BASE) && ((chOff >> 6) < NUM_CH_R);
  assign selCh   = chOff[6 +: CH_W];
  assign winReg  = chOff[5:0];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      startHit[i] = cmdWr && !regWrData[CMD_ABORT_BIT] && regWrData[i];
      abortHit[i] = cmdWr &&  regWrData[CMD_ABORT_BIT] && regWrData[i];
      beatDone[i] = (engState == ENG_WRITE) && memReady && (curCh == CH_W'(i)) && busy[i];
      doneEvt[i]  = abortHit[i] || (beatDone[i] && nextCount == '0) ||
                    (startHit[i] && !busy[i] && count[i] == '0);
      irq[i]      = (reqDone[i] && enDone[i]) || (reqAbort[i] && enAbort[i]);
    end
  end

  // round-robin pick, scanning from the channel after the last grant
  always_comb begin
    pickValid = 1'b0;
    pickCh    = lastCh;
    for (int k = NUM_CH; k >= 1; k--) begin
      int idx;
      idx = (int'(lastCh) + k) % NUM_CH;
      if (busy[idx]) begin
        pickValid = 1'b1;
        pickCh    = CH_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engState <= ENG_IDLE;
      curCh    <= '0;
      lastCh   <= CH_W'(NUM_CH - 1);
    end else begin
      case (engState)
        ENG_IDLE:  if (pickValid) begin
                     curCh    <= pickCh;
                     lastCh   <= pickCh;
                     engState <= ENG_READ;
                   end
        ENG_READ:  if (memReady) engState <= ENG_WRITE;
        ENG_WRITE: if (memReady) engState <= ENG_IDLE;
        default:   engState <= ENG_IDLE;
      endcase
    end
  end

  assign memValid           = (engState != ENG_IDLE);
  assign memWrite           = (engState == ENG_WRITE);
  assign strobe.captureData = (engState == ENG_READ) && memReady;
  assign strobe.writePhase  = (engState == ENG_WRITE);
  assign curSrc     = srcAddr[curCh];
  assign curDst     = dstAddr[curCh];
  assign curSrcMode = srcMode[curCh];
  assign curDstMode = dstMode[curCh];
  assign curCount   = count[curCh];

  // channel state: software write, then beat update, then start, then abort
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        srcAddr[i] <= '0;
        dstAddr[i] <= '0;
        count[i]   <= '0;
        srcMode[i] <= '0;
        dstMode[i] <= '0;
      end
      busy <= '0; reqDone <= '0; reqAbort <= '0; enDone <= '0; enAbort <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (regWrEn && chValid && selCh == CH_W'(i)) begin
          case (winReg)
            OFF_REQ: begin
              if (regWrData[IRQ_DONE_BIT])  reqDone[i]  <= 1'b0;
              if (regWrData[IRQ_ABORT_BIT]) reqAbort[i] <= 1'b0;
            end
            OFF_EN: begin
              enDone[i]  <= regWrData[IRQ_DONE_BIT];
              enAbort[i] <= regWrData[IRQ_ABORT_BIT];
            end
            OFF_SMODE: srcMode[i] <= regWrData[5:4];
            OFF_DMODE: dstMode[i] <= regWrData[5:4];
            OFF_SADDR: srcAddr[i] <= ADDR_W'(regWrData);
            OFF_DADDR: dstAddr[i] <= ADDR_W'(regWrData);
            OFF_COUNT: count[i]   <= ADDR_W'(regWrData);
            default: ;
          endcase
        end
        if (beatDone[i]) begin
          srcAddr[i] <= nextSrc;
          dstAddr[i] <= nextDst;
          count[i]   <= nextCount;
          if (nextCount == '0) begin
            busy[i]    <= 1'b0;
            reqDone[i] <= 1'b1;
          end
        end
        if (startHit[i] && !busy[i]) begin
          if (count[i] == '0) reqDone[i] <= 1'b1;
          else                busy[i]    <= 1'b1;
        end
        if (abortHit[i]) begin
          busy[i]     <= 1'b0;
          reqDone[i]  <= 1'b1;
          reqAbort[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (chValid) begin
      case (winReg)
        OFF_STAT: begin
          regRdData[0]             = busy[selCh];
          regRdData[IRQ_DONE_BIT]  = doneEvt[selCh];
          regRdData[IRQ_ABORT_BIT] = abortHit[selCh];
        end
        OFF_REQ: begin
          regRdData[IRQ_DONE_BIT]  = reqDone[selCh];
          regRdData[IRQ_ABORT_BIT] = reqAbort[selCh];
        end
        OFF_EN: begin
          regRdData[IRQ_DONE_BIT]  = enDone[selCh];
          regRdData[IRQ_ABORT_BIT] = enAbort[selCh];
        end
        OFF_DET: begin
          regRdData[IRQ_DONE_BIT]  = reqDone[selCh] && enDone[selCh];
          regRdData[IRQ_ABORT_BIT] = reqAbort[selCh] && enAbort[selCh];
        end
        OFF_SMODE: regRdData[5:4] = srcMode[selCh];
        OFF_DMODE: regRdData[5:4] = dstMode[selCh];
        OFF_SADDR: regRdData = 32'(srcAddr[selCh]);
        OFF_DADDR: regRdData = 32'(dstAddr[selCh]);
        OFF_COUNT: regRdData = 32'(count[selCh]);
        default: ;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWrite) && $stable(curCh))); // R11

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      abortHit[g] |=> (!busy[g] && reqAbort[g] && reqDone[g])); // R7
    AST_ZERO_START: assert property (@(posedge clk) disable iff (!rstN)
      (startHit[g] && !busy[g] && count[g] == '0 && !abortHit[g]) |=> (reqDone[g] && !busy[g])); // R3
  end
endmodule

// File: rtl/dma_multichan.sv
module dma_multichan
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [2:0]        memBytes,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic [NUM_CH-1:0] irq
);
  dpStrobe_t strobe;
  logic [ADDR_W-1:0] curSrc, curDst, curCount, nextSrc, nextDst, nextCount;
  logic [1:0] curSrcMode, curDstMode;

  dmac_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memValid(memValid),
    .memWrite(memWrite), .memReady(memReady), .irq(irq), .strobe(strobe),
    .curSrc(curSrc), .curDst(curDst), .curSrcMode(curSrcMode),
    .curDstMode(curDstMode), .curCount(curCount), .nextSrc(nextSrc),
    .nextDst(nextDst), .nextCount(nextCount)
  );

  dmac_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curSrc(curSrc), .curDst(curDst),
    .curSrcMode(curSrcMode), .curDstMode(curDstMode), .curCount(curCount),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memBytes(memBytes), .nextSrc(nextSrc), .nextDst(nextDst),
    .nextCount(nextCount)
  );
endmodule

// File: tb/dma_multichan_bench.sv
`timescale 1ns/1ps
module dma_multichan_bench;
  localparam int NUM_CH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memValid, memWrite, memReady;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [2:0] memBytes;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int errors = 0;
  int wrSeen = 0;
  int readyMode = 0;   // 0 always ready, 1 stalled, 2 alternating
  logic [31:0] mem [1024];

  typedef struct { logic [31:0] addr; logic [31:0] data; logic [2:0] bytes; string tag; } beat_t;
  beat_t expQ [$];

  always #4 clk = ~clk;

  dma_multichan u_dma_multichan (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memBytes(memBytes), .memReady(memReady), .memRdata(memRdata), .irq(irq)
  );

  function automatic logic [31:0] patt(input logic [31:0] byteAddr);
    return 32'h5A00_0000 ^ ({22'd0, byteAddr[11:2]} * 32'h0001_0203);
  endfunction

  assign memRdata = mem[memAddr[11:2]];

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = patt(32'(i * 4));
  end

  initial begin
    memReady = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (readyMode)
        0: memReady = 1'b1;
        1: memReady = 1'b0;
        default: memReady = ~memReady;
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare every accepted write beat with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memValid && memReady && memWrite) begin
        wrSeen++;
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected write actual=%h@%h expected=none", memWdata, memAddr);
        end else begin
          beat_t e;
          e = expQ.pop_front();
          check({e.tag, " addr"}, memAddr, e.addr);
          check({e.tag, " data"}, memWdata, e.data);
          check({e.tag, " bytes"}, 32'(memBytes), 32'(e.bytes));
        end
        mem[memAddr[11:2]] = memWdata;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [11:0] chReg(input int ch, input logic [5:0] off);
    return 12'h100 + 12'(ch * 64) + {6'd0, off};
  endfunction

  task automatic setupCh(input int ch, input logic [31:0] src, input logic [1:0] sm,
                         input logic [31:0] dst, input logic [1:0] dm, input logic [31:0] cnt);
    regWrite(chReg(ch, 6'h20), {26'd0, sm, 4'd0});
    regWrite(chReg(ch, 6'h24), {26'd0, dm, 4'd0});
    regWrite(chReg(ch, 6'h28), src);
    regWrite(chReg(ch, 6'h2C), dst);
    regWrite(chReg(ch, 6'h30), cnt);
  endtask

  function automatic logic [31:0] stepOf(input logic [31:0] a, input logic [1:0] m);
    if (m == 2'd0) return a + 4;
    if (m == 2'd1) return a - 4;
    return a;
  endfunction

  // driver: push the expected write beat k of a transfer
  task automatic pushBeat(input string tag, input logic [31:0] src, input logic [1:0] sm,
                          input logic [31:0] dst, input logic [1:0] dm,
                          input logic [31:0] cnt, input int k);
    logic [31:0] s, d, c;
    beat_t b;
    s = src; d = dst; c = cnt;
    for (int j = 0; j < k; j++) begin
      s = stepOf(s, sm); d = stepOf(d, dm); c = c - 4;
    end
    b.addr = d; b.data = patt(s); b.bytes = (c >= 4) ? 3'd4 : c[2:0]; b.tag = tag;
    expQ.push_back(b);
  endtask

  task automatic pushXfer(input string tag, input logic [31:0] src, input logic [1:0] sm,
                          input logic [31:0] dst, input logic [1:0] dm, input logic [31:0] cnt);
    for (int k = 0; k < int'((cnt + 3) / 4); k++) pushBeat(tag, src, sm, dst, dm, cnt, k);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((expQ.size() != 0 || memValid) && n < 3000) begin
      @(negedge clk); n++;
    end
    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", 32'(expQ.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 memValid", 32'(memValid), 32'd0);
    regRead(chReg(0, 6'h30), v); check("R1 count", v, 32'd0);
    regRead(chReg(1, 6'h14), v); check("R1 req", v, 32'd0);
    regRead(chReg(1, 6'h10), v); check("R1 status", v, 32'd0);

    // R2/R10: start both channels in one command, beats alternate from channel 0
    setupCh(0, 32'h000, 2'd0, 32'h600, 2'd0, 32'd8);
    setupCh(1, 32'h200, 2'd0, 32'h700, 2'd0, 32'd8);
    pushBeat("R10 rr ch0b0", 32'h000, 2'd0, 32'h600, 2'd0, 32'd8, 0);
    pushBeat("R10 rr ch1b0", 32'h200, 2'd0, 32'h700, 2'd0, 32'd8, 0);
    pushBeat("R10 rr ch0b1", 32'h000, 2'd0, 32'h600, 2'd0, 32'd8, 1);
    pushBeat("R10 rr ch1b1", 32'h200, 2'd0, 32'h700, 2'd0, 32'd8, 1);
    regWrite(12'h000, 32'h3);
    drain();
    regRead(chReg(0, 6'h28), v); check("R6 ch0 final src", v, 32'h008);
    regRead(chReg(0, 6'h2C), v); check("R6 ch0 final dst", v, 32'h608);
    regRead(chReg(1, 6'h30), v); check("R6 ch1 count zero", v, 32'd0);
    regRead(chReg(0, 6'h14), v); check("R8 done latched", v, 32'h2);
    check("R9 irq low while masked", 32'(irq), 32'd0);
    regWrite(chReg(0, 6'h18), 32'h2);
    @(negedge clk);
    check("R9 irq ch0 only", 32'(irq), 32'b01);
    regRead(chReg(0, 6'h1C), v); check("R8 detect", v, 32'h2);
    regWrite(chReg(0, 6'h14), 32'h2);
    @(negedge clk);
    regRead(chReg(0, 6'h14), v); check("R8 w1c", v, 32'h0);
    check("R9 irq cleared", 32'(irq), 32'd0);
    regWrite(chReg(0, 6'h18), 32'h0);
    regWrite(chReg(1, 6'h14), 32'h2);

    // R4: decrementing source under alternating ready
    readyMode = 2;
    setupCh(0, 32'h0FC, 2'd1, 32'h400, 2'd0, 32'd8);
    pushXfer("R4 dec", 32'h0FC, 2'd1, 32'h400, 2'd0, 32'd8);
    regWrite(12'h000, 32'h1);
    drain();
    regRead(chReg(0, 6'h28), v); check("R4 dec final src", v, 32'h0F4);
    regRead(chReg(0, 6'h2C), v); check("R4 inc final dst", v, 32'h408);

    // R4/R5/R3: fixed destination, short last beat, repeated start ignored
    readyMode = 0;
    setupCh(1, 32'h100, 2'd0, 32'hC00, 2'd2, 32'd10);
    pushXfer("R5 fixed dst", 32'h100, 2'd0, 32'hC00, 2'd2, 32'd10);
    regWrite(12'h000, 32'h2);
    regWrite(12'h000, 32'h2);
    drain();
    regRead(chReg(1, 6'h2C), v); check("R4 fixed dst", v, 32'hC00);
    regRead(chReg(1, 6'h28), v); check("R3 busy start ignored src", v, 32'h10C);

    // R4: fixed source, peripheral to memory
    setupCh(0, 32'h800, 2'd2, 32'h500, 2'd0, 32'd6);
    pushXfer("R4 fixed src", 32'h800, 2'd2, 32'h500, 2'd0, 32'd6);
    regWrite(12'h000, 32'h1);
    drain();
    regRead(chReg(0, 6'h28), v); check("R4 fixed src final", v, 32'h800);

    // R3: zero-byte start
    regWrite(chReg(1, 6'h14), 32'h2002);
    regWrite(chReg(1, 6'h30), 32'd0);
    regWrite(12'h000, 32'h2);
    @(negedge clk);
    regRead(chReg(1, 6'h14), v); check("R3 zero start done", v, 32'h2);
    regRead(chReg(1, 6'h10), v); check("R3 zero start idle", v & 32'h1, 32'h0);
    check("R3 zero start no bus", 32'(memValid), 32'd0);
    regWrite(chReg(1, 6'h14), 32'h2);

    // R6/R7: live count, then abort mid-transfer
    setupCh(1, 32'h300, 2'd0, 32'h900, 2'd0, 32'd40);
    for (int k = 0; k < 3; k++) pushBeat("R7 abort run", 32'h300, 2'd0, 32'h900, 2'd0, 32'd40, k);
    base = wrSeen;
    regWrite(12'h000, 32'h2);
    while (wrSeen < base + 2) @(negedge clk);
    readyMode = 1;
    repeat (4) @(negedge clk);
    regRead(chReg(1, 6'h30), v); check("R6 live count", v, 32'd32);
    regRead(chReg(1, 6'h28), v); check("R6 live src", v, 32'h308);
    regRead(chReg(1, 6'h10), v); check("R8 status busy", v & 32'h1, 32'h1);
    regWrite(12'h000, 32'h8000_0002);
    regRead(chReg(1, 6'h10), v); check("R7 idle after abort", v & 32'h1, 32'h0);
    regRead(chReg(1, 6'h14), v); check("R7 abort and done", v, 32'h2002);
    check("R9 irq masked", 32'(irq), 32'd0);
    regWrite(chReg(1, 6'h18), 32'h2000);
    @(negedge clk);
    check("R9 irq ch1 abort", 32'(irq), 32'b10);
    regRead(chReg(1, 6'h1C), v); check("R8 detect abort", v, 32'h2000);
    readyMode = 0;
    drain();
    regRead(chReg(1, 6'h30), v); check("R7 no update after abort", v, 32'd32);
    regWrite(chReg(1, 6'h14), 32'h2002);
    @(negedge clk);
    check("R9 irq after clear", 32'(irq), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule